// File: doc/BRIEF.md
# Parallel Port EPP Cycle Engine

This block is the host-side sequencer for Enhanced Parallel Port transfers. A CPU-side request selects one of four operations: address write, data write, address read and data read. For a write, the request also supplies a byte. For a read, the engine returns the byte it captured. The engine drives the write-direction line and the two active-low strobes, one for data cycles and one for address cycles. It owns the 8-bit peripheral bus through a split data-out, data-in and output-enable interface.

A peripheral register is first selected by an address cycle. Any sequence of data reads and writes then targets that register. Each cycle is gated at both ends by the peripheral's wait line:
- The strobe is held off until wait is seen low.
- The cycle ends when wait returns high.

The wait input passes through a two-flop synchronizer. A watchdog, sized from the clock-frequency parameter so that it covers 10 µs, aborts any cycle that does not finish in time. It then raises a sticky timeout flag.

While no cycle is running, every peripheral-side output follows a standard-mode control image presented on the `idle_*` inputs.

The controller has five states:
- IDLE: ready, pins follow the control image. A request moves it to HOLD.
- HOLD: direction and bus are set up, no strobe yet. Wait seen low moves it to STROBE. Watchdog expiry moves it to ABORT.
- STROBE: strobe asserted. Wait seen high moves it to FINISH. Otherwise, watchdog expiry moves it to ABORT.
- FINISH: strobe released, clean done pulse. It returns to IDLE.
- ABORT: strobe released, bus released, done pulse with error, timeout flag set. It returns to IDLE.

Top module: `epp_host_engine`

## Requirements
- R1: A request is taken when `req_valid` is high while `req_ready` is high. In the code on `req_op`, bit 1 set means read and bit 0 set means data. So 0 is address write, 1 is data write, 2 is address read and 3 is data read.
- R2: During a cycle, an address operation drives only `pp_astb_n` low and a data operation drives only `pp_dstb_n` low. The two strobes are never low together while busy.
- R3: While busy, `pp_wr_n` is low for write operations and high for read operations.
- R4: No strobe is asserted until the synchronized wait has been seen low. This is at least two clock edges after `pp_wait` falls.
- R5: With the strobe asserted, the synchronized wait seen high ends the cycle. The strobe is released, `done` pulses for one cycle with `done_err` low, and `req_ready` is high the cycle after.
- R6: On a write, `req_wdata` is driven on `pp_data_o` with `pp_data_oe` high and held stable for the whole cycle. On a read, `pp_data_oe` is low while busy. The bus byte is captured into `rdata` at completion and held until the next read completes.
- R7: If `CLK_HZ/1e6*TIMEOUT_US` clock cycles pass from acceptance without completion, the cycle is aborted. At the abort, `done` and `done_err` go high together, both strobes are high and `pp_data_oe` is low. The abort comes exactly that many cycles after acceptance.
- R8: `tmo_flag` rises the cycle after an abort. It stays set until a cycle with `tmo_clr` high. An abort in the same cycle wins over the clear.
- R9: In IDLE, `pp_wr_n`, `pp_dstb_n`, `pp_astb_n` and `pp_data_o` follow their `idle_*` inputs, and `pp_data_oe` equals the inverse of `idle_dir`.
- R10: `pp_init_n` follows `idle_init_n` at all times, busy or idle.
- R11: After reset, `req_ready` is 1, `done` is 0, `tmo_flag` is 0 and `rdata` is 0.
- R12: A `req_valid` raised during a busy cycle is ignored. The running cycle keeps its strobe kind, direction and bus byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (bit1 read, bit0 data) |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Engine idle, request can be taken |
| done | output | 1 | One-cycle end-of-cycle pulse |
| done_err | output | 1 | Cycle ended by watchdog abort |
| rdata | output | 8 | Last byte read |
| tmo_flag | output | 1 | Sticky timeout status |
| tmo_clr | input | 1 | Clears the timeout status |
| idle_data | input | 8 | Control image: bus byte |
| idle_dir | input | 1 | Control image: 1 = bus is input |
| idle_wr_n | input | 1 | Control image: direction line |
| idle_dstb_n | input | 1 | Control image: data strobe |
| idle_astb_n | input | 1 | Control image: address strobe |
| idle_init_n | input | 1 | Control image: peripheral init, active low |
| pp_wait | input | 1 | Peripheral wait, asynchronous |
| pp_data_i | input | 8 | Peripheral bus input |
| pp_data_o | output | 8 | Peripheral bus output |
| pp_data_oe | output | 1 | Peripheral bus output enable |
| pp_wr_n | output | 1 | Write-direction line, low = write |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_init_n | output | 1 | Peripheral init, active low |

## Verification
The hardest situations to reach are the two abort paths. In one, wait never falls and the strobe is never issued. In the other, the strobe is issued but wait never rises. Each runs for the full watchdog window. The bench plays the peripheral and drives these two cases directly. It measures the exact cycle of the abort, then checks that the sticky flag survives a normal cycle before a clear removes it. Stray requests raised mid-cycle are injected during the hold-off phase, where a wrongly accepted request would be most visible.

// File: rtl/epp_pkg.sv
package epp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_STROBE,
        ST_FINISH,
        ST_ABORT
    } epp_state_e;

    // operation code: bit 1 = read, bit 0 = data (R1)
    function automatic logic op_is_read(input logic [1:0] op);
        return op[1];
    endfunction

    function automatic logic op_is_data(input logic [1:0] op);
        return op[0];
    endfunction
endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/epp_seq.sv
module epp_seq
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [7:0] req_wdata,
    input  logic       wait_s,
    input  logic       expired,
    input  logic [7:0] bus_in,
    input  logic       tmo_clr,
    output epp_state_e state,
    output logic [1:0] op_q,
    output logic [7:0] wdata_q,
    output logic [7:0] rdata,
    output logic       tmo_flag,
    output logic       wd_start,
    output logic       wd_run
);
    epp_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = ST_HOLD;
            ST_HOLD:   if (expired) nxt = ST_ABORT;
                       else if (!wait_s) nxt = ST_STROBE;
            ST_STROBE: if (wait_s) nxt = ST_FINISH;
                       else if (expired) nxt = ST_ABORT;
            ST_FINISH: nxt = ST_IDLE;
            ST_ABORT:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            wdata_q  <= '0;
            rdata    <= '0;
            tmo_flag <= 1'b0;
        end else begin
            if (wd_start) begin
                op_q    <= req_op;
                wdata_q <= req_wdata;
            end
            if (state == ST_STROBE && wait_s && op_is_read(op_q))
                rdata <= bus_in;
            if (state == ST_ABORT)  tmo_flag <= 1'b1;
            else if (tmo_clr)       tmo_flag <= 1'b0;
        end
    end

    always_comb begin
        wd_start = (state == ST_IDLE) && req_valid;
        wd_run   = (state == ST_HOLD) || (state == ST_STROBE);
    end
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
    import epp_pkg::*;
#(
    parameter int CLK_HZ     = 250_000_000,
    parameter int TIMEOUT_US = 10,
    parameter int SYNC_STG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [7:0] req_wdata,
    output logic       req_ready,
    output logic       done,
    output logic       done_err,
    output logic [7:0] rdata,
    output logic       tmo_flag,
    input  logic       tmo_clr,
    input  logic [7:0] idle_data,
    input  logic       idle_dir,
    input  logic       idle_wr_n,
    input  logic       idle_dstb_n,
    input  logic       idle_astb_n,
    input  logic       idle_init_n,
    input  logic       pp_wait,
    input  logic [7:0] pp_data_i,
    output logic [7:0] pp_data_o,
    output logic       pp_data_oe,
    output logic       pp_wr_n,
    output logic       pp_dstb_n,
    output logic       pp_astb_n,
    output logic       pp_init_n
);
    localparam int TMO_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    logic       wait_s;
    logic       expired;
    logic       wd_start;
    logic       wd_run;
    epp_state_e state;
    logic [1:0] op_q;
    logic [7:0] wdata_q;

    epp_wait_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pp_wait), .sync_out(wait_s)
    );

    epp_watchdog #(.LIMIT(TMO_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .start(wd_start), .run(wd_run), .expired(expired)
    );

    epp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_wdata(req_wdata), .wait_s(wait_s), .expired(expired),
        .bus_in(pp_data_i), .tmo_clr(tmo_clr), .state(state), .op_q(op_q),
        .wdata_q(wdata_q), .rdata(rdata), .tmo_flag(tmo_flag),
        .wd_start(wd_start), .wd_run(wd_run)
    );

    // pin multiplexer: control image when idle, cycle drive otherwise
    always_comb begin
        pp_init_n  = idle_init_n;
        pp_data_o  = wdata_q;
        pp_wr_n    = op_is_read(op_q);
        pp_dstb_n  = 1'b1;
        pp_astb_n  = 1'b1;
        pp_data_oe = !op_is_read(op_q);
        req_ready  = 1'b0;
        done       = 1'b0;
        done_err   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready  = 1'b1;
                pp_data_o  = idle_data;
                pp_data_oe = !idle_dir;
                pp_wr_n    = idle_wr_n;
                pp_dstb_n  = idle_dstb_n;
                pp_astb_n  = idle_astb_n;
            end
            ST_HOLD: ;
            ST_STROBE: begin
                pp_dstb_n = !op_is_data(op_q);
                pp_astb_n = op_is_data(op_q);
            end
            ST_FINISH: done = 1'b1;
            ST_ABORT: begin
                done       = 1'b1;
                done_err   = 1'b1;
                pp_wr_n    = 1'b1;
                pp_data_oe = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/epp_host_checker.sv
module epp_host_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       done_err,
    input logic       tmo_flag,
    input logic       tmo_clr,
    input logic       pp_wr_n,
    input logic       pp_dstb_n,
    input logic       pp_astb_n,
    input logic       pp_data_oe,
    input logic [7:0] pp_data_o,
    input logic       wait_s
);
    logic stb_on;
    assign stb_on = !pp_dstb_n || !pp_astb_n;

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !(!pp_dstb_n && !pp_astb_n));

    a_r4_strobe_after_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $rose(stb_on)) |-> !$past(wait_s));

    a_r5_finish_on_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_err) |-> $past(wait_s));

    a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

    a_r5_strobes_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pp_dstb_n && pp_astb_n));

    a_r6_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !pp_wr_n) |-> pp_data_oe);

    a_r6_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && pp_wr_n) |-> !pp_data_oe);

    a_r6_write_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready) && pp_data_oe && $past(pp_data_oe))
            |-> $stable(pp_data_o));

    a_r7_abort_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |=> tmo_flag);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !tmo_clr) |=> tmo_flag);
endmodule

bind epp_host_engine epp_host_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .done_err(done_err), .tmo_flag(tmo_flag), .tmo_clr(tmo_clr),
    .pp_wr_n(pp_wr_n), .pp_dstb_n(pp_dstb_n), .pp_astb_n(pp_astb_n),
    .pp_data_oe(pp_data_oe), .pp_data_o(pp_data_o), .wait_s(wait_s)
);

// File: tb/tb_epp_host_engine.sv
`timescale 1ns/1ps
module tb_epp_host_engine;
    localparam int TMO = 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, done, done_err, tmo_flag;
    logic [7:0] rdata;
    logic       tmo_clr = 1'b0;
    logic [7:0] idle_data = '0;
    logic       idle_dir = 1'b0, idle_wr_n = 1'b1, idle_dstb_n = 1'b1;
    logic       idle_astb_n = 1'b1, idle_init_n = 1'b1;
    logic       pp_wait = 1'b1;
    logic [7:0] pp_data_i = '0;
    logic [7:0] pp_data_o;
    logic       pp_data_oe, pp_wr_n, pp_dstb_n, pp_astb_n, pp_init_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] last_rd = '0;
    bit m_wr, m_bus, m_both, m_init;

    always #2 clk = ~clk;

    epp_host_engine dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_wr_n(input logic [1:0] op);
        return op[1];
    endfunction

    task automatic mon(input logic [1:0] op, input logic [7:0] wd);
        if (!req_ready && !done) begin
            if (pp_wr_n !== exp_wr_n(op)) m_wr = 1;
            if (!op[1] && (pp_data_oe !== 1'b1 || pp_data_o !== wd)) m_bus = 1;
            if (op[1] && pp_data_oe !== 1'b0) m_bus = 1;
            if (!pp_dstb_n && !pp_astb_n) m_both = 1;
        end
        if (pp_init_n !== idle_init_n) m_init = 1;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [7:0] wd, input logic [7:0] rd,
                          input int d1, input int d2, input bit noise);
        int low_cnt;
        int k;
        bit early;
        m_wr = 0; m_bus = 0; m_both = 0; m_init = 0; early = 0;
        @(negedge clk);
        req_op = op; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin req_valid = 1'b1; req_op = ~op; req_wdata = ~wd; end
        for (int i = 0; i < d1; i++) begin
            mon(op, wd);
            if (!pp_dstb_n || !pp_astb_n) early = 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        pp_wait = 1'b0;
        low_cnt = 0; k = 0;
        while (pp_dstb_n && pp_astb_n && k < 50) begin
            mon(op, wd); @(negedge clk); low_cnt++; k++;
        end
        chk(!early && low_cnt >= 2, "R4 strobe hold-off", low_cnt, 2);
        chk((pp_dstb_n == !op[0]) && (pp_astb_n == op[0]), "R2 strobe kind",
            {pp_dstb_n, pp_astb_n}, {!op[0], op[0]});
        if (noise) chk(pp_wr_n == exp_wr_n(op), "R12 busy request ignored", pp_wr_n, exp_wr_n(op));
        for (int i = 0; i < d2; i++) begin mon(op, wd); @(negedge clk); end
        pp_data_i = rd; pp_wait = 1'b1;
        k = 0;
        while (!done && k < 50) begin mon(op, wd); @(negedge clk); k++; end
        chk(done && !done_err && pp_dstb_n && pp_astb_n, "R5 clean completion",
            {done, done_err}, 2);
        if (op[1]) last_rd = rd;
        chk(rdata == last_rd, "R6 read capture", rdata, last_rd);
        @(negedge clk);
        chk(req_ready && !done, "R5 ready after done", req_ready, 1);
        chk(!m_wr, "R3 direction line", m_wr, 0);
        chk(!m_bus, "R6 bus drive", m_bus, 0);
        chk(!m_both, "R2 strobes exclusive", m_both, 0);
        chk(!m_init, "R10 init passthrough", m_init, 0);
    endtask

    task automatic run_tmo(input logic [1:0] op, input bit issue_strobe);
        int k;
        @(negedge clk);
        req_op = op; req_wdata = 8'h3c; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (issue_strobe) pp_wait = 1'b0;
        k = 0;
        while (!done && k < TMO + 100) begin @(negedge clk); k++; end
        chk(k == TMO, "R7 abort timing", k, TMO);
        chk(done && done_err, "R7 abort error", {done, done_err}, 3);
        chk(pp_dstb_n && pp_astb_n && !pp_data_oe, "R7 abort releases pins",
            {pp_dstb_n, pp_astb_n, pp_data_oe}, 6);
        @(negedge clk);
        chk(tmo_flag == 1'b1, "R8 flag set after abort", tmo_flag, 1);
        chk(req_ready == 1'b1, "R7 back to idle", req_ready, 1);
        pp_wait = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0e9f1d27));
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !tmo_flag && rdata == 8'h00, "R11 reset state",
            {req_ready, done, tmo_flag}, 4);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            idle_data = 8'($urandom); idle_dir = 1'($urandom); idle_wr_n = 1'($urandom);
            idle_dstb_n = 1'($urandom); idle_astb_n = 1'($urandom); idle_init_n = 1'($urandom);
            @(negedge clk);
            chk(pp_data_o == idle_data && pp_data_oe == !idle_dir && pp_wr_n == idle_wr_n &&
                pp_dstb_n == idle_dstb_n && pp_astb_n == idle_astb_n, "R9 idle follows image",
                {pp_data_oe, pp_wr_n, pp_dstb_n, pp_astb_n}, {!idle_dir, idle_wr_n, idle_dstb_n, idle_astb_n});
            chk(pp_init_n == idle_init_n, "R10 init idle", pp_init_n, idle_init_n);
        end
        idle_dstb_n = 1'b1; idle_astb_n = 1'b1;

        // R1: each of the four operation codes
        run_op(2'd0, 8'h11, 8'h00, 2, 1, 0);
        run_op(2'd1, 8'hA5, 8'h00, 0, 0, 0);
        run_op(2'd2, 8'h00, 8'h5A, 3, 2, 0);
        run_op(2'd3, 8'h00, 8'hC3, 1, 4, 0);
        run_op(2'd1, 8'h7E, 8'h00, 4, 1, 1);  // R12 stray request while busy
        run_op(2'd3, 8'h00, 8'h99, 4, 1, 1);  // R12

        for (int i = 0; i < 40; i++)
            run_op(2'($urandom), 8'($urandom), 8'($urandom),
                   int'($urandom_range(0, 6)), int'($urandom_range(0, 5)), 1'($urandom));

        run_tmo(2'd1, 0);                     // R7 wait never falls
        run_op(2'd0, 8'h42, 8'h00, 1, 1, 0);
        chk(tmo_flag == 1'b1, "R8 flag sticky", tmo_flag, 1);
        @(negedge clk); tmo_clr = 1'b1;
        @(negedge clk); tmo_clr = 1'b0;
        chk(tmo_flag == 1'b0, "R8 flag cleared", tmo_flag, 0);
        run_tmo(2'd2, 1);                     // R7 strobe issued, wait never rises
        chk(rdata == last_rd, "R6 rdata kept after abort", rdata, last_rd);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule